// File: doc/BRIEF.md
# Flat Page Table Walker

This block resolves a translation miss by reading a single entry from a page table held in main memory. The table is a flat array with one 32-bit entry for every possible virtual page, indexed directly by the virtual page number. A walk therefore always costs exactly one extra memory read. That read ends either in a mapping, which returns the physical page number and its permissions, or in a page fault.

A requester pulses `start` with a virtual page number, the table base address and the set of permissions the access needs. The walker then works in four steps:

1. It forms the entry address.
2. It issues one read on a request/response memory port.
3. It checks the entry's valid bit and permission bits.
4. It reports the outcome with a one-cycle `done` pulse.

Only one walk is served at a time. Entry layout: bit 31 is valid, bit 30 is read, bit 29 is write, bit 28 is execute, and the low `PPN_W` bits hold the physical page number.

Top module: `flat_table_walker`

## Requirements
- R1: After reset, `done` and `mem_req` are low, and they stay low until a `start` is accepted.
- R2: A `start` is accepted only while the walker is idle. In the cycle after acceptance, `mem_req` is high and `mem_addr` equals `table_base + vpn*4`, taken modulo 2^ADDR_W from the values present at acceptance.
- R3: `mem_req` stays high with a stable `mem_addr` until a cycle in which `mem_ready` is high. It is low from the next cycle on. Each walk makes exactly one accepted read.
- R4: If entry bit 31 (valid) is clear, the walk ends with `fault`=1, `cause`=2'b01, and `ppn` and `perm` both zero.
- R5: If the entry is valid but a bit set in `need_perm` is clear in the entry permissions, the walk ends with `fault`=1, `cause`=2'b10, and `ppn` and `perm` both zero. `need_perm` bit 2 corresponds to entry bit 30 (read), bit 1 to bit 29 (write) and bit 0 to bit 28 (execute).
- R6: If the entry is valid and grants every permission in `need_perm`, the walk ends with `fault`=0, `cause`=2'b00, `ppn` equal to entry bits PPN_W-1:0, and `perm` equal to entry bits 30:28.
- R7: `done` goes high for exactly one cycle. That cycle is the one after the cycle in which `mem_rvalid` delivered the entry. The result outputs are valid while `done` is high.
- R8: A `start` raised while a walk is in progress, including during the `done` cycle, is ignored. It produces no extra read and does not change the result.
- R9: A clear valid bit takes priority over a permission mismatch, so the cause is 2'b01 even when permissions are also missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| vpn | input | VPN_W | Virtual page number to translate |
| table_base | input | ADDR_W | Byte address of the page table |
| need_perm | input | 3 | Required permissions: bit2 read, bit1 write, bit0 execute |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a page fault |
| cause | output | 2 | 00 none, 01 not mapped, 10 permission denied |
| ppn | output | PPN_W | Physical page number on success |
| perm | output | 3 | Entry permissions on success |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | ADDR_W | Byte address of the entry being read |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 32 | Page table entry returned by memory |

## Verification
The assertions assume that memory behaves as a well-formed responder:

- It returns exactly one `mem_rvalid` pulse for each accepted request.
- It returns that pulse no earlier than the cycle after acceptance.
- It never raises `mem_rvalid` while no read is outstanding.

The bench memory model keeps within these rules. It asserts `mem_ready` only while `mem_req` is high, then raises `mem_rvalid` once, after a random delay of zero or more cycles.

Random walks vary the entry, the required permissions, the base and the page number. Directed walks cover four cases:

- a base that wraps past the top of the address space;
- an unmapped entry that also lacks permissions;
- an empty permission request;
- `start` pulses during the wait and during the `done` cycle.

// File: rtl/flat_table_walker.sv
module flat_table_walker #(
  parameter int VPN_W  = 20,
  parameter int ADDR_W = 32,
  parameter int PPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ADDR_W-1:0] table_base,
  input  logic [2:0]        need_perm,
  output logic              done,
  output logic              fault,
  output logic [1:0]        cause,
  output logic [PPN_W-1:0]  ppn,
  output logic [2:0]        perm,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);

  localparam int ENTRY_BYTES = 4;
  localparam int SHIFT       = $clog2(ENTRY_BYTES);
  localparam logic [1:0] C_NONE  = 2'b00;
  localparam logic [1:0] C_UNMAP = 2'b01;
  localparam logic [1:0] C_PERM  = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t            state;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        need_q;

  logic       ent_valid;
  logic [2:0] ent_perm;
  logic       perm_miss;
  logic       unused_bits;

  assign ent_valid   = mem_rdata[31];
  assign ent_perm    = mem_rdata[30:28];
  assign perm_miss   = |(need_q & ~ent_perm);
  assign unused_bits = ^mem_rdata;

  assign done     = (state == S_DONE);
  assign mem_req  = (state == S_ISSUE);
  assign mem_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      need_q <= '0;
      fault  <= 1'b0;
      cause  <= C_NONE;
      ppn    <= '0;
      perm   <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (start) begin
            addr_q <= table_base + (ADDR_W'(vpn) << SHIFT);
            need_q <= need_perm;
            state  <= S_ISSUE;
          end
        S_ISSUE:
          if (mem_ready) state <= S_WAIT;
        S_WAIT:
          if (mem_rvalid) begin
            state <= S_DONE;
            if (!ent_valid) begin
              fault <= 1'b1;
              cause <= C_UNMAP;
              ppn   <= '0;
              perm  <= '0;
            end else if (perm_miss) begin
              fault <= 1'b1;
              cause <= C_PERM;
              ppn   <= '0;
              perm  <= '0;
            end else begin
              fault <= 1'b0;
              cause <= C_NONE;
              ppn   <= mem_rdata[PPN_W-1:0];
              perm  <= ent_perm;
            end
          end
        default:
          state <= S_IDLE;
      endcase
    end
  end

  a_r2_entry_address: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=>
      (mem_req && mem_addr == $past(table_base) + (ADDR_W'($past(vpn)) << SHIFT)));

  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> !mem_req);

  a_r4_unmapped_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && mem_rvalid && !mem_rdata[31]) |=>
      (done && fault && cause == C_UNMAP && ppn == '0));

  a_r6_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (cause == C_NONE));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_rvalid));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !mem_req);

endmodule

// File: tb/test_flat_table_walker.sv
module test_flat_table_walker;
  localparam int VPN_W = 20, ADDR_W = 32, PPN_W = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [VPN_W-1:0]  vpn = '0;
  logic [ADDR_W-1:0] table_base = '0;
  logic [2:0]        need_perm = '0;
  logic              done, fault, mem_req;
  logic [1:0]        cause;
  logic [PPN_W-1:0]  ppn;
  logic [2:0]        perm;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ready = 1'b0;
  logic              mem_rvalid = 1'b0;
  logic [31:0]       mem_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int acc_cnt  = 0;

  always #10 clk = ~clk;

  flat_table_walker #(.VPN_W(VPN_W), .ADDR_W(ADDR_W), .PPN_W(PPN_W)) i_flat_table_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .vpn(vpn), .table_base(table_base),
    .need_perm(need_perm), .done(done), .fault(fault), .cause(cause), .ppn(ppn),
    .perm(perm), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  always @(posedge clk) if (rst_n && mem_req && mem_ready) acc_cnt++;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_cause(input logic [31:0] e, input logic [2:0] np);
    if (!e[31]) return 2'b01;
    if ((np & ~e[30:28]) != 3'b000) return 2'b10;
    return 2'b00;
  endfunction

  task automatic walk(input logic [VPN_W-1:0] v, input logic [ADDR_W-1:0] b,
                      input logic [2:0] np, input logic [31:0] ent,
                      input int rdly, input int vdly, input bit poke);
    int c0;
    logic [ADDR_W-1:0] ea;
    logic [1:0] ec;
    c0 = acc_cnt;
    ea = b + (ADDR_W'(v) << 2);
    ec = exp_cause(ent, np);
    @(negedge clk);
    start = 1'b1; vpn = v; table_base = b; need_perm = np;
    @(negedge clk);
    start = 1'b0; vpn = $urandom; table_base = $urandom; need_perm = $urandom;
    check(mem_req == 1'b1, "R2 req", 64'(mem_req), 64'd1);
    check(mem_addr == ea, "R2 addr", 64'(mem_addr), 64'(ea));
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk);
      check(mem_req && mem_addr == ea, "R3 hold", 64'(mem_addr), 64'(ea));
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    check(!mem_req, "R3 drop", 64'(mem_req), 64'd0);
    if (poke) begin start = 1'b1; vpn = ~v; end
    for (int i = 0; i < vdly; i++) begin
      @(negedge clk);
      start = 1'b0;
      check(!done && !mem_req, "R8 wait", 64'({done, mem_req}), 64'd0);
    end
    mem_rvalid = 1'b1; mem_rdata = ent;
    @(negedge clk);
    mem_rvalid = 1'b0; start = 1'b0; mem_rdata = $urandom;
    check(done == 1'b1, "R7 done", 64'(done), 64'd1);
    check(cause == ec, "R4/R5/R9 cause", 64'(cause), 64'(ec));
    check(fault == (ec != 2'b00), "R4/R5 fault", 64'(fault), 64'(ec != 2'b00));
    if (ec == 2'b00) begin
      check(ppn == ent[PPN_W-1:0], "R6 ppn", 64'(ppn), 64'(ent[PPN_W-1:0]));
      check(perm == ent[30:28], "R6 perm", 64'(perm), 64'(ent[30:28]));
    end else begin
      check(ppn == '0 && perm == '0, "R4/R5 zero", 64'({perm, ppn}), 64'd0);
    end
    if (poke) begin start = 1'b1; vpn = v ^ 1; end
    @(negedge clk);
    start = 1'b0;
    check(!done, "R7 pulse", 64'(done), 64'd0);
    @(negedge clk);
    check(!mem_req, "R8 ignored", 64'(mem_req), 64'd0);
    check(acc_cnt == c0 + 1, "R3 R8 one read", 64'(acc_cnt - c0), 64'd1);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(!done && !mem_req, "R1 in reset", 64'({done, mem_req}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !mem_req, "R1 after reset", 64'({done, mem_req}), 64'd0);

    walk(20'h00010, 32'h0010_0000, 3'b100, 32'hC000_0ABC, 0, 0, 0);
    walk(20'h00008, 32'hFFFF_FFF0, 3'b000, 32'hF001_2345, 2, 1, 0);
    walk(20'h12345, 32'h0020_0000, 3'b111, 32'h7000_1111, 1, 2, 0);
    walk(20'h00001, 32'h0000_1000, 3'b010, 32'hA000_2222, 0, 3, 0);
    walk(20'h00002, 32'h0000_1000, 3'b111, 32'h0000_3333, 3, 0, 0);
    walk(20'hFFFFF, 32'h0000_0000, 3'b001, 32'h9FFF_FFFF, 1, 1, 1);
    walk(20'h00ABC, 32'h4000_0000, 3'b011, 32'hB000_4444, 0, 0, 1);

    for (int n = 0; n < 200; n++) begin
      walk(VPN_W'($urandom), $urandom, 3'($urandom), $urandom,
           int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule